// File: doc/BRIEF.md
# Infrared Serial Pulse Encoder/Decoder

This block sits between a UART's serial pins and an infrared transceiver. It converts the UART's level-coded serial stream into short light pulses and turns received pulses back into a level-coded stream. On transmit, every zero bit leaving the UART becomes one active-high pulse on the infrared output. One bits leave the output low. The pulse width is either 3/16 of a bit period or three periods of a separate low-power reference tick, whichever mode is selected. On receive, each low-going pulse on the infrared input becomes a zero bit on the recovered serial line, held for a full bit period.

The block runs on the 16x oversampling tick from the UART's baud generator. It finds bit boundaries by watching the UART serial output: a change of level marks oversample tick 0 of a new bit, and a bit with no change starts every 16 ticks. Infrared mode is active only when both the UART enable and the infrared enable are set. While it is active, the wired transmit pin is held high and the wired receive pin is ignored. Two loopback paths exist. One is electrical: UART output to UART input. The other is optical-style: the infrared output, inverted, is fed into the infrared decoder.

Top module: `sir_endec`

## Requirements
- R1: With infrared active and normal width selected, a zero bit drives `sirOut` high from the clock edge of oversample tick 7 of the bit until the edge of tick 10, which is exactly 3 tick periods. Ticks are numbered from 0, and tick 0 is the tick at which a new `uartTxd` level is first sampled, or the 16th tick of an unchanged level.
- R2: A one bit (`uartTxd` = 1) produces no pulse; `sirOut` stays low for the whole bit.
- R3: With `lowPower` = 1, a zero bit raises `sirOut` at the edge of tick 7 and lowers it at the edge of the third `lpTick` after the rise. An `lpTick` on the rising edge itself does not count. The width does not depend on the baud tick.
- R4: When infrared is inactive (`uartEn` = 0 or `sirEn` = 0), `sirOut` stays low, `sirIn` has no effect, and `serialIn` follows `rxdLine`. Setting `sirEn` alone, without `uartEn`, changes nothing.
- R5: `txdLine` is held high while infrared is active and follows `uartTxd` otherwise.
- R6: While infrared is active, `rxdLine` has no effect and `serialIn` is the decoder output, which is 1 when idle.
- R7: `sirIn` is active low. It passes through a 2-stage synchroniser and is sampled on each baud tick. At the first tick that samples it low after a high sample, `serialIn` goes to 0. It returns to 1 at the 16th tick after that, so a pulse one tick wide is enough.
- R8: A new pulse start detected on the very tick where the zero window would end restarts the window, so pulses 16 ticks apart give a continuous zero.
- R9: With `loopback` = 1, `sirTest` = 1 and infrared active, the decoder takes the inverted `sirOut` instead of `sirIn`. A transmitted zero therefore reappears on `serialIn` at tick 8 of the bit, and `sirIn` is ignored.
- R10: With `loopback` = 1 and `sirTest` = 0, or with `loopback` = 1 and infrared inactive, `serialIn` equals `uartTxd`.
- R11: After reset `sirOut` is 0 and the decoder output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| lpTick | input | 1 | One-cycle strobe of the low-power width reference |
| uartEn | input | 1 | UART enable |
| sirEn | input | 1 | Infrared mode enable |
| lowPower | input | 1 | Select pulse width from `lpTick` |
| loopback | input | 1 | Loopback enable |
| sirTest | input | 1 | Route loopback through the infrared path |
| uartTxd | input | 1 | Serial output of the UART transmitter |
| rxdLine | input | 1 | Wired receive pin |
| sirIn | input | 1 | Infrared receiver input, pulses active low |
| sirOut | output | 1 | Infrared transmitter output, pulses active high |
| txdLine | output | 1 | Wired transmit pin |
| serialIn | output | 1 | Serial input to the UART receiver |

## Verification
The assertions assume that `uartTxd` changes only on a baud tick and holds steady for the 16 ticks of a bit. They also assume that `lpTick` keeps running while a low-power pulse is high, and that the width mode is not switched in the middle of a pulse. The stimulus sends every bit as a group of 64 clocks, with a tick every 4 clocks. It draws the low-power tick period and phase at random, from a range that always ends the pulse inside the bit. The decoder runs also come in multiples of 16 ticks, so the encoder's bit phase stays aligned across runs.

// File: rtl/sir_endec_pkg.sv
package sir_endec_pkg;
  typedef struct packed {
    logic sirActive;  // UART and infrared both enabled
    logic lpMode;     // pulse width from low-power tick
    logic loopSir;    // decoder fed from inverted encoder output
    logic loopUart;   // receive line taken from UART output
    logic tick;       // 16x baud tick
    logic lpTick;     // low-power reference tick
    logic pulseSet;   // start a pulse this cycle
    logic pulseEnd;   // normal-width pulse ends this cycle
  } sir_strobe_t;
endpackage

// File: rtl/sir_ctrl.sv
module sir_ctrl
  import sir_endec_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int PULSE_START = 7,
  parameter int PULSE_LEN   = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        baudTick16,
  input  logic        lpTick,
  input  logic        uartEn,
  input  logic        sirEn,
  input  logic        lowPower,
  input  logic        loopback,
  input  logic        sirTest,
  input  logic        uartTxd,
  output sir_strobe_t strobe
);
  localparam int PHASE_W = $clog2(OVS);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(OVS - 1);
  localparam logic [PHASE_W-1:0] SET_PHASE  = PHASE_W'(PULSE_START);
  localparam logic [PHASE_W-1:0] END_PHASE  = PHASE_W'(PULSE_START + PULSE_LEN);

  logic [PHASE_W-1:0] phaseQ, nextPhase;
  logic prevTxdQ;
  logic sirActive;

  // a level change marks tick 0 of a new bit; otherwise count and wrap
  always_comb begin
    if (uartTxd != prevTxdQ)       nextPhase = '0;
    else if (phaseQ == LAST_PHASE) nextPhase = '0;
    else                           nextPhase = phaseQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= LAST_PHASE;
      prevTxdQ <= 1'b1;
    end else if (baudTick16) begin
      phaseQ   <= nextPhase;
      prevTxdQ <= uartTxd;
    end
  end

  assign sirActive = uartEn & sirEn;

  always_comb begin
    strobe.sirActive = sirActive;
    strobe.lpMode    = lowPower;
    strobe.loopSir   = loopback & sirTest & sirActive;
    strobe.loopUart  = loopback & ~(sirTest & sirActive);
    strobe.tick      = baudTick16;
    strobe.lpTick    = lpTick;
    strobe.pulseSet  = baudTick16 & sirActive & ~uartTxd & (nextPhase == SET_PHASE);
    strobe.pulseEnd  = baudTick16 & (nextPhase == END_PHASE);
  end
endmodule

// File: rtl/sir_datapath.sv
module sir_datapath
  import sir_endec_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int PULSE_LEN   = 3,
  parameter int LP_LEN      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  sir_strobe_t strobe,
  input  logic        uartTxd,
  input  logic        rxdLine,
  input  logic        sirIn,
  output logic        sirOut,
  output logic        txdLine,
  output logic        serialIn
);
  localparam int PHASE_W  = $clog2(OVS);
  localparam int LP_CNT_W = (LP_LEN > 1) ? $clog2(LP_LEN) : 1;
  localparam logic [LP_CNT_W-1:0] LP_LAST  = LP_CNT_W'(LP_LEN - 1);
  localparam logic [PHASE_W-1:0] HOLD_LAST = PHASE_W'(OVS - 1);

  // ---------------- encoder ----------------
  logic pulseQ;
  logic [LP_CNT_W-1:0] lpCntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseQ <= 1'b0;
      lpCntQ <= '0;
    end else if (!strobe.sirActive) begin
      pulseQ <= 1'b0;
    end else if (strobe.pulseSet) begin
      pulseQ <= 1'b1;
      lpCntQ <= '0;
    end else if (pulseQ) begin
      if (strobe.lpMode) begin
        if (strobe.lpTick) begin
          if (lpCntQ == LP_LAST) pulseQ <= 1'b0;
          else                   lpCntQ <= lpCntQ + 1'b1;
        end
      end else if (strobe.pulseEnd) begin
        pulseQ <= 1'b0;
      end
    end
  end

  assign sirOut  = pulseQ & strobe.sirActive;
  assign txdLine = strobe.sirActive | uartTxd;

  // ---------------- decoder ----------------
  logic decRaw, rxSync;
  logic [SYNC_STAGES-1:0] syncQ;

  assign decRaw = !strobe.sirActive ? 1'b1 : (strobe.loopSir ? ~pulseQ : sirIn);

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= decRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], decRaw};
      end
    end
  endgenerate

  assign rxSync = syncQ[SYNC_STAGES-1];

  logic prevSampleQ, decOutQ;
  logic [PHASE_W-1:0] holdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSampleQ <= 1'b1;
      decOutQ     <= 1'b1;
      holdQ       <= '0;
    end else if (strobe.tick) begin
      prevSampleQ <= rxSync;
      if (prevSampleQ && !rxSync) begin
        decOutQ <= 1'b0;
        holdQ   <= '0;
      end else if (!decOutQ) begin
        if (holdQ == HOLD_LAST) decOutQ <= 1'b1;
        holdQ <= holdQ + 1'b1;
      end
    end
  end

  always_comb begin
    if (strobe.loopUart)       serialIn = uartTxd;
    else if (strobe.sirActive) serialIn = decOutQ;
    else                       serialIn = rxdLine;
  end

  // ---------------- checks ----------------
  logic [3:0] ticksInPulseQ, lpInPulseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ticksInPulseQ <= '0;
      lpInPulseQ    <= '0;
    end else if (!pulseQ) begin
      ticksInPulseQ <= '0;
      lpInPulseQ    <= '0;
    end else begin
      if (strobe.tick && ticksInPulseQ != 4'hF)  ticksInPulseQ <= ticksInPulseQ + 1'b1;
      if (strobe.lpTick && lpInPulseQ != 4'hF)   lpInPulseQ    <= lpInPulseQ + 1'b1;
    end
  end

  // R1
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseQ && !strobe.lpMode) |-> (ticksInPulseQ <= 4'(PULSE_LEN)));

  // R3
  lp_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseQ && strobe.lpMode) |-> (lpInPulseQ <= 4'(LP_LEN)));

  // R7
  dec_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(decOutQ) |-> ($past(strobe.tick) && !$past(rxSync)));
endmodule

// File: rtl/sir_endec.sv
module sir_endec
  import sir_endec_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int PULSE_START = 7,
  parameter int PULSE_LEN   = 3,
  parameter int LP_LEN      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic baudTick16,
  input  logic lpTick,
  input  logic uartEn,
  input  logic sirEn,
  input  logic lowPower,
  input  logic loopback,
  input  logic sirTest,
  input  logic uartTxd,
  input  logic rxdLine,
  input  logic sirIn,
  output logic sirOut,
  output logic txdLine,
  output logic serialIn
);
  sir_strobe_t strobe;

  sir_ctrl #(
    .OVS(OVS), .PULSE_START(PULSE_START), .PULSE_LEN(PULSE_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick16(baudTick16), .lpTick(lpTick),
    .uartEn(uartEn), .sirEn(sirEn), .lowPower(lowPower), .loopback(loopback),
    .sirTest(sirTest), .uartTxd(uartTxd), .strobe(strobe)
  );

  sir_datapath #(
    .OVS(OVS), .PULSE_LEN(PULSE_LEN), .LP_LEN(LP_LEN), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .uartTxd(uartTxd),
    .rxdLine(rxdLine), .sirIn(sirIn), .sirOut(sirOut), .txdLine(txdLine),
    .serialIn(serialIn)
  );

  // R2
  zero_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sirOut) |-> !uartTxd);
endmodule

// File: tb/sir_endec_tb.sv
module sir_endec_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, baudTick16, lpTick, uartEn, sirEn, lowPower, loopback, sirTest;
  logic uartTxd, rxdLine, sirIn, sirOut, txdLine, serialIn;

  sir_endec u_dut (
    .clk(clk), .rstN(rstN), .baudTick16(baudTick16), .lpTick(lpTick),
    .uartEn(uartEn), .sirEn(sirEn), .lowPower(lowPower), .loopback(loopback),
    .sirTest(sirTest), .uartTxd(uartTxd), .rxdLine(rxdLine), .sirIn(sirIn),
    .sirOut(sirOut), .txdLine(txdLine), .serialIn(serialIn)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic sirLog [0:63];
  logic serLog [0:63];
  logic txdLog [0:63];
  logic rxLog  [0:191];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit tk, input bit lp);
    baudTick16 = tk;
    lpTick     = lp;
    @(posedge clk);
    @(negedge clk);
    baudTick16 = 1'b0;
    lpTick     = 1'b0;
  endtask

  task automatic sendBit(input bit b, input int lpPer, input int lpPh);
    uartTxd = b;
    for (int c = 0; c < 64; c++) begin
      cyc(c % 4 == 0, lpPer > 0 && ((c + lpPh) % lpPer) == 0);
      sirLog[c] = sirOut;
      serLog[c] = serialIn;
      txdLog[c] = txdLine;
    end
  endtask

  task automatic runRx(input int n, input int s1, input int e1, input int s2, input int e2);
    for (int c = 0; c < n; c++) begin
      sirIn = !((c >= s1 && c < e1) || (c >= s2 && c < e2));
      cyc(c % 4 == 0, 1'b0);
      rxLog[c] = serialIn;
    end
    sirIn = 1'b1;
  endtask

  function automatic int firstHigh();
    for (int c = 0; c < 64; c++) if (sirLog[c]) return c;
    return -1;
  endfunction

  function automatic int highCount();
    int n = 0;
    for (int c = 0; c < 64; c++) if (sirLog[c]) n++;
    return n;
  endfunction

  function automatic int lpFall(input int per, input int ph);
    int n = 0;
    for (int c = 29; c < 64; c++) begin
      if (((c + ph) % per) == 0) n++;
      if (n == 3) return c;
    end
    return -1;
  endfunction

  function automatic int rxFirst(input bit v, input int from, input int n);
    for (int c = from; c < n; c++) if (rxLog[c] == v) return c;
    return -1;
  endfunction

  task automatic checkEnc(input bit b, input bit lp, input int per, input int ph, input string req);
    int expFirst = b ? -1 : 28;
    int expCnt   = b ? 0 : (lp ? lpFall(per, ph) - 28 : 12);
    chk(firstHigh() == expFirst, req, firstHigh(), expFirst);
    chk(highCount() == expCnt, req, highCount(), expCnt);
  endtask

  task automatic checkRx(input int s, input int w, input string req);
    int expFall = ((s + 2 + 3) / 4) * 4;
    int expRise = expFall + 64;
    runRx(128, s, s + 4 * w, -1, -1);
    chk(rxFirst(1'b0, 0, 128) == expFall, req, rxFirst(1'b0, 0, 128), expFall);
    chk(rxFirst(1'b1, expFall, 128) == expRise, req, rxFirst(1'b1, expFall, 128), expRise);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; baudTick16 = 1'b0; lpTick = 1'b0;
    uartEn = 1'b0; sirEn = 1'b0; lowPower = 1'b0; loopback = 1'b0; sirTest = 1'b0;
    uartTxd = 1'b1; rxdLine = 1'b1; sirIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(sirOut == 1'b0, "R11", sirOut, 0);
    chk(serialIn == 1'b1, "R11", serialIn, 1);
    uartEn = 1'b1; sirEn = 1'b1;
    cyc(1'b0, 1'b0);
    chk(serialIn == 1'b1, "R11", serialIn, 1);
    chk(txdLine == 1'b1, "R5", txdLine, 1);

    // R1 R2 directed
    sendBit(1'b1, 0, 0); checkEnc(1'b1, 1'b0, 0, 0, "R2");
    sendBit(1'b0, 0, 0); checkEnc(1'b0, 1'b0, 0, 0, "R1");
    chk(txdLog[20] == 1'b1, "R5", txdLog[20], 1);
    sendBit(1'b0, 0, 0); checkEnc(1'b0, 1'b0, 0, 0, "R1 repeat zero");
    sendBit(1'b1, 0, 0); checkEnc(1'b1, 1'b0, 0, 0, "R2");

    // R3 directed
    lowPower = 1'b1;
    sendBit(1'b0, 5, 3); checkEnc(1'b0, 1'b1, 5, 3, "R3");
    sendBit(1'b0, 7, 0); checkEnc(1'b0, 1'b1, 7, 0, "R3");

    // random mix R1 R2 R3
    for (int i = 0; i < 24; i++) begin
      bit b  = 1'($urandom % 2);
      bit lp = 1'($urandom % 2);
      int per = 3 + int'($urandom % 5);
      int ph  = int'($urandom % per);
      lowPower = lp;
      sendBit(b, per, ph);
      checkEnc(b, lp, per, ph, b ? "R2 rand" : (lp ? "R3 rand" : "R1 rand"));
    end
    lowPower = 1'b0;

    // R4 infrared off
    sirEn = 1'b0;
    sendBit(1'b0, 0, 0);
    chk(highCount() == 0, "R4", highCount(), 0);
    chk(txdLog[20] == 1'b0, "R5", txdLog[20], 0);
    uartEn = 1'b0; sirEn = 1'b1;
    sendBit(1'b0, 0, 0);
    chk(highCount() == 0, "R4 sir without uart", highCount(), 0);
    chk(txdLog[40] == 1'b0, "R4 sir without uart", txdLog[40], 0);
    sendBit(1'b1, 0, 0);
    rxdLine = 1'b1;
    runRx(128, 10, 30, -1, -1);
    chk(rxFirst(1'b0, 0, 128) == -1, "R4 sirIn ignored", rxFirst(1'b0, 0, 128), -1);
    rxdLine = 1'b0;
    cyc(1'b0, 1'b0);
    chk(serialIn == 1'b0, "R4 follows rxdLine", serialIn, 0);

    // R6 wired receive ignored when active
    uartEn = 1'b1;
    cyc(1'b0, 1'b0);
    chk(serialIn == 1'b1, "R6", serialIn, 1);
    runRx(128, -1, -1, -1, -1);
    chk(rxFirst(1'b0, 0, 128) == -1, "R6", rxFirst(1'b0, 0, 128), -1);
    rxdLine = 1'b1;

    // R7 decoder directed and random
    checkRx(1, 3, "R7");
    checkRx(4, 1, "R7 one tick");
    for (int i = 0; i < 6; i++) checkRx(1 + int'($urandom % 4), 1 + int'($urandom % 3), "R7 rand");

    // R8 back-to-back pulses
    runRx(192, 1, 5, 65, 69);
    chk(rxFirst(1'b0, 0, 192) == 4, "R8", rxFirst(1'b0, 0, 192), 4);
    chk(rxFirst(1'b1, 4, 192) == 132, "R8", rxFirst(1'b1, 4, 192), 132);

    // R9 inverted infrared loopback
    loopback = 1'b1; sirTest = 1'b1;
    cyc(1'b0, 1'b0);
    sirIn = 1'b0;
    sendBit(1'b0, 0, 0);
    chk(serLog[31] == 1'b1, "R9", serLog[31], 1);
    chk(serLog[32] == 1'b0, "R9", serLog[32], 0);
    sendBit(1'b1, 0, 0);
    chk(serLog[31] == 1'b0, "R9", serLog[31], 0);
    chk(serLog[32] == 1'b1, "R9", serLog[32], 1);
    sirIn = 1'b1;

    // R10 wired loopback
    sirTest = 1'b0;
    sendBit(1'b0, 0, 0);
    chk(serLog[5] == 1'b0, "R10", serLog[5], 0);
    chk(txdLog[5] == 1'b1, "R5", txdLog[5], 1);
    sendBit(1'b1, 0, 0);
    chk(serLog[5] == 1'b1, "R10", serLog[5], 1);
    uartEn = 1'b0; rxdLine = 1'b1;
    sendBit(1'b0, 0, 0);
    chk(serLog[5] == 1'b0, "R10 inactive", serLog[5], 0);
    loopback = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule